// File: doc/BRIEF.md
# Dual-Bank Flash Reset Recovery Controller

This block models how a two-bank NOR-style flash device behaves around its active-low hardware reset pin. It sits next to a program/erase engine and a command decoder. It watches the reset pin, the chip-enable pin, a supply-good indication and one busy flag per bank, and it tells the rest of the device when the data bus may be driven and when each bank may be read again.

How long recovery takes depends on what each bank was doing when the reset pin fell. A bank that was idle opens after a short window, 500 ns by default. A bank that was programming or erasing needs a long window, 11 µs by default. While such a bank is still recovering, the ready/busy output is held low. Such a bank also raises a sticky "data suspect" flag, which stays up until the host clears it, because the interrupted locations hold bad data.

Both windows are derived from a clock-frequency parameter and rounded up to whole cycles. All pin inputs pass through two-flop synchronizers. Every output is registered.

Top module: `flash_rst_recovery`

## Requirements
- R1: After the synchronous system reset, the outputs are as follows: `dout_en`=0, `bank_access`=0, `stale_data`=0, `rdy_n_busy`=1 and `standby`=0. The reset pin is treated as asserted until two clean samples say otherwise.
- R2: `dout_en` is 1 only when the reset pin is high, chip enable is low and supply is good. It goes to 0 by the third clock edge after the reset pin falls, and it stays 0 for as long as the pin is held low, whatever chip enable does.
- R3: A bank that was idle when the reset pin fell has `bank_access` rise exactly 2+SHORT_CYC clock edges after the pin is driven high.
- R4: A bank that was busy when the reset pin fell has `bank_access` rise exactly 2+LONG_CYC edges after release.
- R5: `rdy_n_busy` is 0 while any bank is busy outside reset, and while any bank is in a long recovery. It returns to 1 after recovery. Resetting a device with no bank busy never drives it to 0.
- R6: A reset that falls on a busy bank sets that bank's `stale_data` bit. The bit survives later resets and is cleared only by a one-cycle pulse on that bank's `stale_clr` bit.
- R7: A new fall of the reset pin during a recovery count restarts that count. Each bank's busy state is re-sampled at the new fall.
- R8: While supply-good is low, no bank is accessible and recovery counting pauses. Counting resumes when supply returns, so access rises 2+SHORT_CYC edges after supply is raised.
- R9: `standby` is 1 only when chip enable and the reset pin are both high, no bank is busy and no long recovery is pending. It is never 1 together with `dout_en`.
- R10: SHORT_CYC = ceil(CLK_HZ·SHORT_NS/1e9) and LONG_CYC = ceil(CLK_HZ·LONG_NS/1e9). The defaults give 50 and 1100 cycles.
- R11: Busy flags and chip enable are ignored while the reset pin is held low. They do not lower `rdy_n_busy`, do not raise `dout_en` or `standby`, and do not set `stale_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high system reset |
| pin_rst_n | input | 1 | Asynchronous hardware reset pin, active low |
| pin_ce_n | input | 1 | Asynchronous chip enable pin, active low |
| supply_ok | input | 1 | Asynchronous supply-good indication |
| bank_busy | input | NUM_BANKS | Per-bank program/erase running flags |
| stale_clr | input | NUM_BANKS | Synchronous per-bank clear of the data-suspect flag |
| dout_en | output | 1 | Data output enable; 0 tri-states the bus |
| rdy_n_busy | output | 1 | Ready (1) / busy (0) level for an open-drain pin |
| bank_access | output | NUM_BANKS | Per-bank read access allowed |
| standby | output | 1 | Device in standby |
| stale_data | output | NUM_BANKS | Per-bank sticky flag: interrupted locations need rewriting |

## Verification
The assertions assume that `stale_clr` is synchronous to `clk`. They also assume that the program/erase engine drops its busy flags while the reset pin is held, since in a real device the reset aborts it. The stimulus changes pins only on falling clock edges and holds each level for several cycles, so the synchronizers never see a glitch shorter than two samples. The bench always lowers the busy flags during the reset hold and well before release, so any busy state seen after release comes from a deliberate later stimulus.

// File: rtl/frr_pkg.sv
package frr_pkg;
  // Ceiling conversion of a duration in ns to clock cycles.
  function automatic int unsigned ns_to_cycles(input longint unsigned clk_hz,
                                               input longint unsigned dur_ns);
    longint unsigned prod;
    prod = clk_hz * dur_ns + 64'd999_999_999;
    return int'(prod / 64'd1_000_000_000);
  endfunction
endpackage

// File: rtl/frr_sync.sv
module frr_sync #(
  parameter int unsigned    W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/frr_bank_timer.sv
module frr_bank_timer #(
  parameter int unsigned SHORT_CYC = 50,
  parameter int unsigned LONG_CYC  = 1100,
  parameter int unsigned CW        = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_act,
  input  logic assert_evt,
  input  logic supply_ok,
  input  logic busy,
  input  logic clr_stale,
  output logic open_q,
  output logic long_pend,
  output logic stale_q
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= CW'(SHORT_CYC);
      long_pend <= 1'b0;
      open_q    <= 1'b0;
      stale_q   <= 1'b0;
    end else begin
      if (assert_evt) begin
        long_pend <= busy;
        cnt       <= busy ? CW'(LONG_CYC) : CW'(SHORT_CYC);
        open_q    <= 1'b0;
      end else if (rst_act || !supply_ok) begin
        open_q <= 1'b0;
      end else if (!open_q) begin
        if (cnt > CW'(1)) begin
          cnt <= cnt - CW'(1);
        end else begin
          open_q    <= 1'b1;
          long_pend <= 1'b0;
        end
      end

      if (assert_evt && busy) begin
        stale_q <= 1'b1;
      end else if (clr_stale) begin
        stale_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_rst_recovery.sv
module flash_rst_recovery #(
  parameter longint unsigned CLK_HZ    = 100_000_000,
  parameter longint unsigned SHORT_NS  = 500,
  parameter longint unsigned LONG_NS   = 11_000,
  parameter int unsigned     NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pin_rst_n,
  input  logic                 pin_ce_n,
  input  logic                 supply_ok,
  input  logic [NUM_BANKS-1:0] bank_busy,
  input  logic [NUM_BANKS-1:0] stale_clr,
  output logic                 dout_en,
  output logic                 rdy_n_busy,
  output logic [NUM_BANKS-1:0] bank_access,
  output logic                 standby,
  output logic [NUM_BANKS-1:0] stale_data
);
  localparam int unsigned SHORT_CYC = frr_pkg::ns_to_cycles(CLK_HZ, SHORT_NS);
  localparam int unsigned LONG_CYC  = frr_pkg::ns_to_cycles(CLK_HZ, LONG_NS);
  localparam int unsigned CW        = $clog2(LONG_CYC + 1);
  localparam int unsigned SW        = NUM_BANKS + 3;
  // Pin sync reset values: reset pin asserted, deselected, supply not good, idle.
  localparam logic [SW-1:0] SYNC_RST = {{NUM_BANKS{1'b0}}, 1'b0, 1'b1, 1'b0};

  logic [SW-1:0]        pins_s;
  logic                 rstpin_s, ce_n_s, supply_s;
  logic [NUM_BANKS-1:0] busy_s;
  logic                 rst_act, rst_act_d, assert_evt;
  logic [NUM_BANKS-1:0] long_pend;

  frr_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bank_busy, supply_ok, pin_ce_n, pin_rst_n}),
    .q   (pins_s)
  );

  assign rstpin_s = pins_s[0];
  assign ce_n_s   = pins_s[1];
  assign supply_s = pins_s[2];
  assign busy_s   = pins_s[SW-1:3];

  assign rst_act    = ~rstpin_s;
  assign assert_evt = rst_act & ~rst_act_d;

  always_ff @(posedge clk) begin
    if (rst) rst_act_d <= 1'b1;
    else     rst_act_d <= rst_act;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    frr_bank_timer #(
      .SHORT_CYC (SHORT_CYC),
      .LONG_CYC  (LONG_CYC),
      .CW        (CW)
    ) u_timer (
      .clk        (clk),
      .rst        (rst),
      .rst_act    (rst_act),
      .assert_evt (assert_evt),
      .supply_ok  (supply_s),
      .busy       (busy_s[b]),
      .clr_stale  (stale_clr[b]),
      .open_q     (bank_access[b]),
      .long_pend  (long_pend[b]),
      .stale_q    (stale_data[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_en    <= 1'b0;
      rdy_n_busy <= 1'b1;
      standby    <= 1'b0;
    end else begin
      dout_en    <= ~rst_act & ~ce_n_s & supply_s;
      rdy_n_busy <= ~((|busy_s & ~rst_act) | (|long_pend));
      standby    <= ce_n_s & rstpin_s & ~(|busy_s) & ~(|long_pend);
    end
  end
endmodule

// File: rtl/frr_checker.sv
module frr_checker #(
  parameter int unsigned NB = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          rst_act,
  input logic          supply_s,
  input logic [NB-1:0] long_pend,
  input logic [NB-1:0] stale_clr,
  input logic          dout_en,
  input logic          rdy_n_busy,
  input logic          standby,
  input logic [NB-1:0] bank_access,
  input logic [NB-1:0] stale_data
);
  p_bus_off_in_reset_r2: assert property (@(posedge clk) disable iff (rst)
    rst_act |=> !dout_en);

  p_closed_in_reset_r3: assert property (@(posedge clk) disable iff (rst)
    rst_act |=> bank_access == '0);

  p_busy_while_long_r5: assert property (@(posedge clk) disable iff (rst)
    (long_pend != '0) |=> !rdy_n_busy);

  p_closed_no_supply_r8: assert property (@(posedge clk) disable iff (rst)
    !supply_s |=> bank_access == '0);

  p_standby_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(standby && dout_en));

  for (genvar b = 0; b < NB; b++) begin : g_chk
    p_stale_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      (stale_data[b] && !stale_clr[b]) |=> stale_data[b]);
  end
endmodule

bind flash_rst_recovery frr_checker #(.NB(NUM_BANKS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rst_act     (rst_act),
  .supply_s    (supply_s),
  .long_pend   (long_pend),
  .stale_clr   (stale_clr),
  .dout_en     (dout_en),
  .rdy_n_busy  (rdy_n_busy),
  .standby     (standby),
  .bank_access (bank_access),
  .stale_data  (stale_data)
);

// File: tb/tb_flash_rst_recovery.sv
module tb_flash_rst_recovery;
  localparam longint unsigned F_HZ = 100_000_000;
  localparam longint unsigned S_NS = 500;
  localparam longint unsigned L_NS = 11_000;
  localparam int SHORT = int'((F_HZ * S_NS + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int LONG  = int'((F_HZ * L_NS + 64'd999_999_999) / 64'd1_000_000_000);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_rst_n = 1'b0, pin_ce_n = 1'b1, supply_ok = 1'b0;
  logic [1:0] bank_busy = 2'b00, stale_clr = 2'b00;
  logic       dout_en, rdy_n_busy, standby;
  logic [1:0] bank_access, stale_data;
  logic [1:0] exp_stale = 2'b00;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  flash_rst_recovery #(.CLK_HZ(F_HZ), .SHORT_NS(S_NS), .LONG_NS(L_NS),
                       .NUM_BANKS(2)) dut (
    .clk(clk), .rst(rst), .pin_rst_n(pin_rst_n), .pin_ce_n(pin_ce_n),
    .supply_ok(supply_ok), .bank_busy(bank_busy), .stale_clr(stale_clr),
    .dout_en(dout_en), .rdy_n_busy(rdy_n_busy), .bank_access(bank_access),
    .standby(standby), .stale_data(stale_data)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called right after pin_rst_n is driven high at a falling edge.
  task automatic measure(output int k0, output int k1);
    k0 = 0; k1 = 0;
    for (int k = 1; k <= LONG + 6; k++) begin
      @(posedge clk); #1;
      if (bank_access[0] && k0 == 0) k0 = k;
      if (bank_access[1] && k1 == 0) k1 = k;
    end
    @(negedge clk);
  endtask

  task automatic recovery(input logic [1:0] pat);
    int k0, k1;
    bank_busy = pat;
    cyc(6);
    chk("R5 busy lowers ready", rdy_n_busy, (pat != 0) ? 0 : 1);
    pin_rst_n = 1'b0;
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    chk("R2 bus off in reset", dout_en, 0);
    @(negedge clk);
    pin_ce_n = 1'b1; cyc(3);
    pin_ce_n = 1'b0; cyc(3);
    chk("R2 bus stays off in reset", dout_en, 0);
    bank_busy = 2'b00;
    cyc(6);
    chk("R5 ready during long recovery", rdy_n_busy, (pat != 0) ? 0 : 1);
    exp_stale |= pat;
    chk("R6 stale set on busy reset", stale_data, exp_stale);
    pin_rst_n = 1'b1;
    measure(k0, k1);
    chk(pat[0] ? "R4 bank0 long window" : "R3 bank0 short window", k0,
        2 + (pat[0] ? LONG : SHORT));
    chk(pat[1] ? "R4 bank1 long window" : "R3 bank1 short window", k1,
        2 + (pat[1] ? LONG : SHORT));
    chk("R5 ready after recovery", rdy_n_busy, 1);
    chk("R2 bus back on", dout_en, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k0, k1;
    cyc(3);
    chk("R1 dout_en", dout_en, 0);
    chk("R1 bank_access", bank_access, 0);
    chk("R1 stale_data", stale_data, 0);
    chk("R1 ready", rdy_n_busy, 1);
    chk("R1 standby", standby, 0);
    rst = 1'b0;
    chk("R10 short cycles", SHORT, 50);
    chk("R10 long cycles", LONG, 1100);

    // Power-up: supply good first, then release reset.
    supply_ok = 1'b1; pin_ce_n = 1'b0; cyc(8);
    chk("R8 no access before release", bank_access, 0);
    pin_rst_n = 1'b1;
    measure(k0, k1);
    chk("R3 power-up bank0", k0, 2 + SHORT);
    chk("R3 power-up bank1", k1, 2 + SHORT);

    // Sweep every busy pattern.
    for (int p = 0; p < 4; p++) recovery(2'(p));

    // R7 restart: busy reset, early re-assertion while idle.
    bank_busy = 2'b11; cyc(6);
    pin_rst_n = 1'b0; cyc(6);
    bank_busy = 2'b00; cyc(6);
    pin_rst_n = 1'b1; cyc(20);
    chk("R7 closed mid long count", bank_access, 0);
    pin_rst_n = 1'b0; cyc(8);
    pin_rst_n = 1'b1;
    measure(k0, k1);
    chk("R7 restart bank0 short", k0, 2 + SHORT);
    chk("R7 restart bank1 short", k1, 2 + SHORT);
    exp_stale = 2'b11;
    chk("R6 stale survives reset", stale_data, exp_stale);
    stale_clr = 2'b01; cyc(1); stale_clr = 2'b00;
    chk("R6 clear bank0 only", stale_data, 2'b10);
    stale_clr = 2'b10; cyc(1); stale_clr = 2'b00;
    chk("R6 clear bank1", stale_data, 2'b00);

    // R11: busy and chip enable ignored during hold.
    pin_rst_n = 1'b0; cyc(6);
    bank_busy = 2'b11; pin_ce_n = 1'b1; cyc(6);
    chk("R11 ready ignores busy in reset", rdy_n_busy, 1);
    chk("R11 no standby in reset", standby, 0);
    chk("R11 no bus in reset", dout_en, 0);
    bank_busy = 2'b00; pin_ce_n = 1'b0; cyc(6);
    pin_rst_n = 1'b1;
    measure(k0, k1);
    chk("R11 bank0 short after busy in hold", k0, 2 + SHORT);
    chk("R11 bank1 short after busy in hold", k1, 2 + SHORT);
    chk("R11 no stale from hold", stale_data, 0);

    // R9 standby.
    pin_ce_n = 1'b1; cyc(5);
    chk("R9 standby when deselected", standby, 1);
    chk("R9 bus off in standby", dout_en, 0);
    bank_busy = 2'b01; cyc(5);
    chk("R9 busy keeps device active", standby, 0);
    bank_busy = 2'b00; cyc(5);
    chk("R9 standby after busy ends", standby, 1);
    pin_ce_n = 1'b0; cyc(5);
    chk("R9 selected leaves standby", standby, 0);

    // R8 supply loss pauses recovery.
    supply_ok = 1'b0; cyc(5);
    chk("R8 access drops without supply", bank_access, 0);
    pin_rst_n = 1'b0; cyc(8);
    pin_rst_n = 1'b1; cyc(100);
    chk("R8 no access while supply low", bank_access, 0);
    supply_ok = 1'b1;
    measure(k0, k1);
    chk("R8 bank0 after supply", k0, 2 + SHORT);
    chk("R8 bank1 after supply", k1, 2 + SHORT);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule